// File: doc/BRIEF.md
# Wait-for-Interrupt Standby Controller

This block parks a processor core in a low-power standby state and brings it back. The core reports each coprocessor register write by giving the coprocessor number and the opcode and register fields. Two encodings ask for standby: a current one and an older one kept so that legacy software still works. When either is seen, the block drives the clock-gate enable low, and the gated core clock stops at the high level.

While parked, the block watches four wake sources: the active-low fast interrupt line, the active-low normal interrupt line, an external debug request line, and a debug-request control bit. The three external lines are asynchronous, so they pass through a multi-stage synchroniser. Interrupt wake-up takes no account of the core's interrupt-mask state. Debug wake-up counts only while the debug-enable input is high.

On wake-up the block releases the clock. In the same cycle it gives a one-cycle cause code. This code tells the core to take the pending interrupt, or to enter debug state, before it executes the next instruction.

Top module: `wfi_standby_ctrl`

## Requirements
- R1: A write with cp_wr_valid=1, cp_num=15, cp_opc1=0, cp_crn=7, cp_crm=0, cp_opc2=4 while running drives core_clk_en low from the next rising edge.
- R2: The legacy encoding cp_wr_valid=1, cp_num=15, cp_opc1=0, cp_crn=15, cp_crm=8, cp_opc2=2 also enters standby from the next rising edge.
- R3: Any other write leaves core_clk_en high. This covers a different opcode2, a different opcode1, a different CRm, another coprocessor number, or valid low.
- R4: While core_clk_en is low, core_clk is held at logic high. While core_clk_en is high, core_clk follows clk.
- R5: A low level on fiq_n or irq_n wakes the core. No mask input exists, so interrupt wake-up does not depend on any mask state.
- R6: dbg_req_ext or dbg_req_bit wakes the core only while dbg_en is high. dbg_en is sampled on each rising edge, after the request has passed through the synchroniser.
- R7: wake_cause is a one-cycle pulse in the first cycle after wake-up: 2'b01 for an interrupt, 2'b10 for debug, and 2'b00 at all other times. Debug wins when both are seen in the same cycle.
- R8: After reset, core_clk_en is 1 and wake_cause is 2'b00.
- R9: A wake input that is stable before rising edge k ends standby at edge k+SYNC_STAGES (k+2 by default). Standby is still in force after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_wr_valid | input | 1 | Coprocessor register write strobe |
| cp_num | input | 4 | Coprocessor number |
| cp_opc1 | input | 3 | Opcode field 1 |
| cp_crn | input | 4 | Primary coprocessor register |
| cp_crm | input | 4 | Secondary coprocessor register |
| cp_opc2 | input | 3 | Opcode field 2 |
| fiq_n | input | 1 | Fast interrupt, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt, active low, asynchronous |
| dbg_req_ext | input | 1 | External debug request, asynchronous |
| dbg_req_bit | input | 1 | Debug-request control bit |
| dbg_en | input | 1 | Debug enable, synchronous |
| core_clk_en | output | 1 | Clock-gate enable; low while in standby |
| core_clk | output | 1 | Gated core clock, held high in standby |
| wake_cause | output | 2 | One-cycle wake cause code |

## Verification
Some properties are checked by assertions on every cycle:
- Standby is entered exactly on the two decoded encodings and never on any other write.
- The gated clock is high whenever the enable is low.
- The cause code is one-hot or zero.
- The cause code appears only in the cycle in which the enable rises.

The bench scenarios are needed for the rest:
- The synchroniser latency.
- The blocking of debug wake while debug is disabled, and the release when it is enabled.
- Debug priority over a simultaneous interrupt.
- The absence of any cause pulse for interrupts that arrive while the core is already running.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_IRQ  = 2'b01,
      CAUSE_DBG  = 2'b10
   } wake_cause_e;

   // Wake source bit positions inside the synchronised vector
   localparam int SRC_FIQ  = 0;
   localparam int SRC_IRQ  = 1;
   localparam int SRC_DEXT = 2;
   localparam int SRC_DBIT = 3;
   localparam int SRC_W    = 4;
endpackage

// File: rtl/wfi_decode.sv
module wfi_decode #(
   parameter int CP_W      = 4,
   parameter int OPC_W     = 3,
   parameter int CR_W      = 4,
   parameter int CP_NUM    = 15,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic             wr_valid,
   input  logic [CP_W-1:0]  num,
   input  logic [OPC_W-1:0] opc1,
   input  logic [CR_W-1:0]  crn,
   input  logic [CR_W-1:0]  crm,
   input  logic [OPC_W-1:0] opc2,
   output logic             hit
);
   localparam logic [CP_W-1:0] NUM_V = CP_W'(CP_NUM);

   initial begin
      if (CP_NUM >= (1 << CP_W)) $error("CP_NUM does not fit in CP_W bits");
      if (CR_W < 4 || OPC_W < 3) $error("field widths too small for standby encodings");
   end

   logic base_ok, prim_hit, leg_hit;

   assign base_ok  = wr_valid && (num == NUM_V) && (opc1 == '0);
   assign prim_hit = base_ok && (crn == CR_W'(7)) && (crm == '0) && (opc2 == OPC_W'(4));

   generate
      if (LEGACY_EN) begin : g_legacy
         assign leg_hit = base_ok && (crn == CR_W'(15)) && (crm == CR_W'(8)) && (opc2 == OPC_W'(2));
      end else begin : g_no_legacy
         assign leg_hit = 1'b0;
      end
   endgenerate

   assign hit = prim_hit || leg_hit;
endmodule

// File: rtl/wfi_sync.sv
module wfi_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2) $error("synchroniser needs at least two stages");
      if (WIDTH < 1)  $error("WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/wfi_clkgate.sv
module wfi_clkgate (
   input  logic clk,
   input  logic en,
   output logic gclk
);
   // Enable captured while clk is high, so it is stable through the low
   // phase. The OR gate then parks the output high when disabled.
   logic en_lat;

   always_latch begin
      if (clk) en_lat = en;
   end

   assign gclk = clk | ~en_lat;
endmodule

// File: rtl/wfi_standby_ctrl.sv
module wfi_standby_ctrl
   import wfi_pkg::*;
#(
   parameter int CP_W        = 4,
   parameter int OPC_W       = 3,
   parameter int CR_W        = 4,
   parameter int CP_NUM      = 15,
   parameter int SYNC_STAGES = 2,
   parameter bit LEGACY_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cp_wr_valid,
   input  logic [CP_W-1:0]  cp_num,
   input  logic [OPC_W-1:0] cp_opc1,
   input  logic [CR_W-1:0]  cp_crn,
   input  logic [CR_W-1:0]  cp_crm,
   input  logic [OPC_W-1:0] cp_opc2,
   input  logic             fiq_n,
   input  logic             irq_n,
   input  logic             dbg_req_ext,
   input  logic             dbg_req_bit,
   input  logic             dbg_en,
   output logic             core_clk_en,
   output logic             core_clk,
   output logic [1:0]       wake_cause
);
   logic              req_hit;
   logic [SRC_W-1:0]  src_raw, src_s;
   logic              wake_irq, wake_dbg;
   logic              asleep_q;
   wake_cause_e       cause_q;

   wfi_decode #(
      .CP_W(CP_W), .OPC_W(OPC_W), .CR_W(CR_W),
      .CP_NUM(CP_NUM), .LEGACY_EN(LEGACY_EN)
   ) u_dec (
      .wr_valid(cp_wr_valid), .num(cp_num), .opc1(cp_opc1),
      .crn(cp_crn), .crm(cp_crm), .opc2(cp_opc2), .hit(req_hit)
   );

   // All sources made active-high before synchronisation
   always_comb begin
      src_raw           = '0;
      src_raw[SRC_FIQ]  = ~fiq_n;
      src_raw[SRC_IRQ]  = ~irq_n;
      src_raw[SRC_DEXT] = dbg_req_ext;
      src_raw[SRC_DBIT] = dbg_req_bit;
   end

   wfi_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_s)
   );

   assign wake_irq = src_s[SRC_FIQ] | src_s[SRC_IRQ];
   assign wake_dbg = dbg_en & (src_s[SRC_DEXT] | src_s[SRC_DBIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
         cause_q  <= CAUSE_NONE;
      end else if (!asleep_q) begin
         cause_q <= CAUSE_NONE;
         if (req_hit) asleep_q <= 1'b1;
      end else if (wake_dbg) begin
         asleep_q <= 1'b0;
         cause_q  <= CAUSE_DBG;
      end else if (wake_irq) begin
         asleep_q <= 1'b0;
         cause_q  <= CAUSE_IRQ;
      end else begin
         cause_q  <= CAUSE_NONE;
      end
   end

   assign core_clk_en = ~asleep_q;
   assign wake_cause  = cause_q;

   wfi_clkgate u_gate (.clk(clk), .en(core_clk_en), .gclk(core_clk));
endmodule

// File: rtl/wfi_standby_chk.sv
module wfi_standby_chk #(
   parameter int CP_W   = 4,
   parameter int OPC_W  = 3,
   parameter int CR_W   = 4,
   parameter int CP_NUM = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cp_wr_valid,
   input logic [CP_W-1:0]  cp_num,
   input logic [OPC_W-1:0] cp_opc1,
   input logic [CR_W-1:0]  cp_crn,
   input logic [CR_W-1:0]  cp_crm,
   input logic [OPC_W-1:0] cp_opc2,
   input logic             core_clk_en,
   input logic             core_clk,
   input logic [1:0]       wake_cause
);
   logic fmt_ok, is_new, is_old;
   assign fmt_ok = cp_wr_valid && (cp_num == CP_W'(CP_NUM)) && (cp_opc1 == '0);
   assign is_new = fmt_ok && cp_crn == CR_W'(7)  && cp_crm == '0        && cp_opc2 == OPC_W'(4);
   assign is_old = fmt_ok && cp_crn == CR_W'(15) && cp_crm == CR_W'(8)  && cp_opc2 == OPC_W'(2);

   // R1
   enter_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && is_new) |=> !core_clk_en);
   // R2
   enter_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && is_old) |=> !core_clk_en);
   // R3
   no_spurious_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && !is_new && !is_old) |=> core_clk_en);
   // R4
   gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> core_clk);
   // R7
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake_cause));
   // R7
   cause_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_cause != 2'b00) |-> $rose(core_clk_en));
endmodule

bind wfi_standby_ctrl wfi_standby_chk #(
   .CP_W(CP_W), .OPC_W(OPC_W), .CR_W(CR_W), .CP_NUM(CP_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cp_wr_valid(cp_wr_valid), .cp_num(cp_num),
   .cp_opc1(cp_opc1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_opc2(cp_opc2),
   .core_clk_en(core_clk_en), .core_clk(core_clk), .wake_cause(wake_cause)
);

// File: tb/wfi_standby_ctrl_tb.sv
`timescale 1ns/1ps
module wfi_standby_ctrl_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cp_wr_valid = 1'b0;
   logic [3:0] cp_num = '0, cp_crn = '0, cp_crm = '0;
   logic [2:0] cp_opc1 = '0, cp_opc2 = '0;
   logic fiq_n = 1'b1, irq_n = 1'b1, dbg_req_ext = 1'b0, dbg_req_bit = 1'b0, dbg_en = 1'b0;
   logic core_clk_en, core_clk;
   logic [1:0] wake_cause;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   wfi_standby_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cp_wr_valid(cp_wr_valid), .cp_num(cp_num),
      .cp_opc1(cp_opc1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_opc2(cp_opc2),
      .fiq_n(fiq_n), .irq_n(irq_n), .dbg_req_ext(dbg_req_ext),
      .dbg_req_bit(dbg_req_bit), .dbg_en(dbg_en),
      .core_clk_en(core_clk_en), .core_clk(core_clk), .wake_cause(wake_cause)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cp_write(input logic v, input logic [3:0] num, input logic [2:0] o1,
                           input logic [3:0] rn, input logic [3:0] rm, input logic [2:0] o2);
      @(negedge clk);
      cp_wr_valid = v; cp_num = num; cp_opc1 = o1; cp_crn = rn; cp_crm = rm; cp_opc2 = o2;
      @(negedge clk);
      cp_wr_valid = 1'b0;
   endtask

   // {valid, cp_num, opc1, crn, crm, opc2, expect_standby}
   localparam int NV = 9;
   localparam logic [19:0] VEC [NV] = '{
      {1'b1, 4'd15, 3'd0, 4'd7,  4'd0, 3'd4, 1'b1},  // R1 primary
      {1'b1, 4'd15, 3'd0, 4'd15, 4'd8, 3'd2, 1'b1},  // R2 legacy
      {1'b1, 4'd15, 3'd0, 4'd7,  4'd0, 3'd5, 1'b0},  // R3 wrong opc2
      {1'b1, 4'd15, 3'd1, 4'd7,  4'd0, 3'd4, 1'b0},  // R3 wrong opc1
      {1'b1, 4'd14, 3'd0, 4'd7,  4'd0, 3'd4, 1'b0},  // R3 wrong coprocessor
      {1'b1, 4'd15, 3'd0, 4'd7,  4'd5, 3'd4, 1'b0},  // R3 wrong crm
      {1'b1, 4'd15, 3'd0, 4'd15, 4'd8, 3'd4, 1'b0},  // R3 legacy crn, wrong opc2
      {1'b0, 4'd15, 3'd0, 4'd7,  4'd0, 3'd4, 1'b0},  // R3 valid low
      {1'b1, 4'd15, 3'd0, 4'd7,  4'd0, 3'd4, 1'b1}   // R1 again
   };

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R8 reset state
      chk("R8 clk_en", {3'b0, core_clk_en}, 4'h1);
      chk("R8 cause", {2'b0, wake_cause}, 4'h0);
      rst_n = 1'b1;
      cyc(2);

      for (int v = 0; v < NV; v++) begin
         logic [19:0] e;
         e = VEC[v];
         @(negedge clk);
         cp_wr_valid = e[19]; cp_num = e[18:15]; cp_opc1 = e[14:12];
         cp_crn = e[11:8]; cp_crm = e[7:4]; cp_opc2 = e[3:1];
         @(negedge clk);
         cp_wr_valid = 1'b0;
         chk(e[0] ? "R1/R2 standby entry" : "R3 ignored write",
             {3'b0, core_clk_en}, {3'b0, ~e[0]});
         if (e[0]) begin
            // R4 gated clock parked high, sampled low phase of clk
            chk("R4 core_clk high", {3'b0, core_clk}, 4'h1);
            cyc(3);
            chk("R4 still asleep", {3'b0, core_clk_en}, 4'h0);
            // R5 wake via fast interrupt
            fiq_n = 1'b0;
            cyc(2);
            chk("R9 asleep after one edge", {3'b0, core_clk_en}, 4'h0);
            cyc(1);
            chk("R5 awake", {3'b0, core_clk_en}, 4'h1);
            chk("R7 cause irq", {2'b0, wake_cause}, 4'h1);
            fiq_n = 1'b1;
            cyc(1);
            chk("R7 cause pulse ends", {2'b0, wake_cause}, 4'h0);
            cyc(3);
         end else begin
            chk("R4 core_clk follows clk", {3'b0, core_clk}, 4'h0);
         end
      end

      // R5 normal interrupt line
      cp_write(1'b1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd4);
      irq_n = 1'b0;
      cyc(3);
      chk("R5 irq_n wake", {2'b0, wake_cause, core_clk_en}, 4'h3);
      irq_n = 1'b1;
      cyc(4);

      // R6 debug wake blocked while dbg_en low
      cp_write(1'b1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd4);
      dbg_req_ext = 1'b1;
      cyc(6);
      chk("R6 dbg blocked", {3'b0, core_clk_en}, 4'h0);
      chk("R6 no cause", {2'b0, wake_cause}, 4'h0);
      dbg_en = 1'b1;
      cyc(1);
      chk("R6 dbg wake", {3'b0, core_clk_en}, 4'h1);
      chk("R7 cause dbg", {2'b0, wake_cause}, 4'h2);
      dbg_req_ext = 1'b0;
      cyc(4);

      // R6 debug-request control bit path
      cp_write(1'b1, 4'd15, 3'd0, 4'd15, 4'd8, 3'd2);
      dbg_req_bit = 1'b1;
      cyc(3);
      chk("R6 dbg bit wake", {2'b0, wake_cause, core_clk_en}, 4'h5);
      dbg_req_bit = 1'b0;
      cyc(4);

      // R7 priority: debug and interrupt together
      cp_write(1'b1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd4);
      fiq_n = 1'b0; dbg_req_bit = 1'b1;
      cyc(3);
      chk("R7 debug priority", {2'b0, wake_cause, core_clk_en}, 4'h5);
      fiq_n = 1'b1; dbg_req_bit = 1'b0;
      cyc(4);

      // R7 interrupt while running gives no cause
      irq_n = 1'b0;
      cyc(5);
      chk("R7 no cause while running", {2'b0, wake_cause, core_clk_en}, 4'h1);
      irq_n = 1'b1;
      cyc(4);

      // R8 reset while asleep
      cp_write(1'b1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd4);
      rst_n = 1'b0;
      cyc(1);
      chk("R8 reset wakes", {2'b0, wake_cause, core_clk_en}, 4'h1);
      rst_n = 1'b1;
      cyc(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule